// File: doc/BRIEF.md
# One-Shot Memory-to-Memory Transfer Channel

This block is a single transfer channel that moves data across a shared 20-bit memory bus on behalf of a processor. Software loads a source pointer, a destination pointer and a count reload value, picks a unit size and an addressing mode, and then sets the enable bit. From then on, each request moves exactly one unit. A request comes from a software request register or from an external request pin. The channel first takes the bus from the processor and reads the unit. It then writes the unit back and returns the bus. The channel runs through a fixed number of transfers and then stops by itself. When it stops, it clears its enable bit and raises an interrupt flag.

The channel keeps its own running read pointer. This pointer is copied from the source pointer when the first request after activation is accepted. The transfer counter is loaded from the reload register at that same moment. Every finished transfer lowers the counter by one. A transfer that finds the counter at zero makes it wrap to all ones. That wrap is the underflow that ends the sequence, so a reload value of N gives N+1 transfers.

The bus sequencer has six states. `ST_IDLE` waits for an accepted request. `ST_REQ` holds the bus request until the grant arrives. `ST_DUM_IN` is one dead cycle after the grant. `ST_READ` drives the read strobe at the running pointer. `ST_WRITE` drives the write strobe at the destination. `ST_DUM_OUT` is one dead cycle with the bus request already dropped. The transitions are: IDLE→REQ on a pending request while enabled, REQ→DUM_IN on grant, DUM_IN→READ, READ→WRITE, WRITE→DUM_OUT, and DUM_OUT→IDLE. Every other case holds the current state.

Top module: `dma_oneshot_chan`

## Requirements
- R1: After reset, the control word, interrupt flag, counter and running pointer all read 0. The bus request and both strobes are low.
- R2: Control bit 4 selects the trigger: 1 means software, 0 means external pin. With software selected, writing 1 to bit 0 of register 4 requests a transfer, and `ext_req` has no effect. With the pin selected, a one-cycle pulse on `ext_req` requests a transfer, and the software request has no effect.
- R3: While control bit 0 (enable) is 0, requests are dropped and not stored. No bus request follows, even after the channel is enabled later.
- R4: When the first request after enable goes 0→1 is accepted, the counter (register 7) is loaded from the reload register (register 2) and the running pointer (register 6) is loaded from the source pointer (register 0).
- R5: A transfer proceeds as follows. `bus_req` rises and holds until `bus_gnt`. Then comes one dummy cycle. Then one read cycle at the running pointer. Then one write cycle at the destination pointer (register 1), carrying the data that was read. Then one dummy cycle with `bus_req` low.
- R6: Each finished transfer lowers the counter by one, and the counter wraps from 0 to all ones. With reload 1, the counter reads 01, then 00, then FF.
- R7: The transfer that takes the counter from 0 to all ones clears the enable bit and sets the interrupt flag (register 5 bit 0, and output `irq`) on the same clock edge.
- R8: The interrupt flag is cleared by a pulse on `irq_ack` or by writing 0 to bit 0 of register 5.
- R9: When an underflow and an acknowledge fall on the same edge, the flag ends up set.
- R10: Control bit 1 selects the unit size: 1 means 16 bits, 0 means 8 bits. `bus_wide` follows it. An 8-bit write carries the low byte and zeros the upper byte. The advancing pointer steps by 2 for 16-bit units and by 1 for 8-bit units.
- R11: Control bits 3:2 select the addressing mode. 0 keeps both pointers fixed. 1 advances only the running pointer. 2 advances only the destination pointer. 3 behaves as 0.
- R12: Pointers wrap within 20 bits.
- R13: A request that arrives while a transfer is in progress is held. It is served right after the current transfer, and at most one such request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select (0 src, 1 dst, 2 reload, 3 control, 4 sw request, 5 irq flag, 6 running pointer, 7 counter) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data for `reg_sel` (combinational) |
| ext_req | input | 1 | External transfer request pulse |
| irq_ack | input | 1 | Interrupt accepted, clears the flag |
| irq | output | 1 | Interrupt flag |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | 20 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wide | output | 1 | 1 for a 16-bit unit, 0 for an 8-bit unit |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of the read cycle |

## Verification
Two events can land on the same clock edge. The first is the underflow that ends the last transfer. The second is an interrupt acknowledge, which could wipe out the flag that the underflow has just raised. The bench provokes this by pulsing `irq_ack` during the write cycle of the final transfer of a two-transfer run. It then checks that the flag is still set one cycle later, together with the cleared enable bit. A second overlap is a new request arriving while the bus is busy. The bench issues it during the grant wait and checks that a second complete bus sequence follows right after the dummy cycle.

// File: rtl/dma_oneshot_pkg.sv
`timescale 1ns/1ps
package dma_oneshot_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_SRC    = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DST    = 3'd1;
    localparam logic [SEL_W-1:0] SEL_RELOAD = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_SWREQ  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_IRQ    = 3'd5;
    localparam logic [SEL_W-1:0] SEL_RUNPTR = 3'd6;
    localparam logic [SEL_W-1:0] SEL_COUNT  = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_DUM_IN  = 3'd2,
        ST_READ    = 3'd3,
        ST_WRITE   = 3'd4,
        ST_DUM_OUT = 3'd5
    } xfer_state_e;

    typedef enum logic [1:0] {
        MODE_FIXED   = 2'd0,
        MODE_SRC_RUN = 2'd1,
        MODE_DST_RUN = 2'd2,
        MODE_RSVD    = 2'd3
    } xfer_mode_e;

    // control word: bit4 sw trigger, bits3:2 mode, bit1 wide, bit0 enable
    typedef struct packed {
        logic       sw_sel;
        xfer_mode_e mode;
        logic       wide;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dma_req_gate.sv
`timescale 1ns/1ps
module dma_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sw_sel,
    input  logic sw_hit,
    input  logic ext_req,
    input  logic take,
    output logic pend
);

    logic hit;

    always_comb begin
        hit = sw_sel ? sw_hit : ext_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (!en) begin
            pend <= 1'b0;
        end else if (hit) begin
            pend <= 1'b1;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    // R3
    dropped_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> !pend);

    // R13
    held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit) |=> pend);

endmodule

// File: rtl/dma_bus_fsm.sv
`timescale 1ns/1ps
module dma_bus_fsm
    import dma_oneshot_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wide,
    input  logic [ADDR_W-1:0] rd_ptr,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              take,
    output logic              done,
    output logic              bus_req,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_wide,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    localparam int BYTE_W = 8;
    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'({BYTE_W{1'b1}});

    xfer_state_e state, state_nx;
    logic [DATA_W-1:0] hold_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (go) state_nx = ST_REQ;
            ST_REQ:     if (bus_gnt) state_nx = ST_DUM_IN;
            ST_DUM_IN:  state_nx = ST_READ;
            ST_READ:    state_nx = ST_WRITE;
            ST_WRITE:   state_nx = ST_DUM_OUT;
            ST_DUM_OUT: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state == ST_READ) begin
            hold_q <= wide ? bus_rdata : (bus_rdata & LOW_MASK);
        end
    end

    // outputs
    always_comb begin
        take      = 1'b0;
        done      = 1'b0;
        bus_req   = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_wide  = wide;
        unique case (state)
            ST_IDLE: begin
                take = go;
            end
            ST_REQ, ST_DUM_IN: begin
                bus_req = 1'b1;
            end
            ST_READ: begin
                bus_req  = 1'b1;
                bus_rd   = 1'b1;
                bus_addr = rd_ptr;
            end
            ST_WRITE: begin
                bus_req   = 1'b1;
                bus_wr    = 1'b1;
                bus_addr  = wr_ptr;
                bus_wdata = hold_q;
                done      = 1'b1;
            end
            ST_DUM_OUT: begin
                bus_req = 1'b0;
            end
            default: begin
                bus_req = 1'b0;
            end
        endcase
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R5
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);

    // R5
    release_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (!bus_req && !bus_rd && !bus_wr));

    // R5
    dummy_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd) |-> $past(bus_req && !bus_wr));

endmodule

// File: rtl/dma_regfile.sv
`timescale 1ns/1ps
module dma_regfile
    import dma_oneshot_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              take,
    input  logic              done,
    input  logic              irq_ack,
    output ctrl_t             ctrl,
    output logic              sw_hit,
    output logic [ADDR_W-1:0] run_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(1);

    logic [ADDR_W-1:0] src_ptr;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  count_q;
    logic              fresh_q;
    logic              wr_ctrl, wr_irq, underflow;
    logic [ADDR_W-1:0] step;

    always_comb begin
        wr_ctrl   = reg_we && (reg_sel == SEL_CTRL);
        wr_irq    = reg_we && (reg_sel == SEL_IRQ);
        sw_hit    = reg_we && (reg_sel == SEL_SWREQ) && reg_wdata[0];
        underflow = done && (count_q == '0);
        step      = ctrl.wide ? STEP_WIDE : STEP_NARROW;
    end

    // software-owned pointers and reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr  <= '0;
            reload_q <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_SRC)    src_ptr  <= reg_wdata;
            if (reg_sel == SEL_RELOAD) reload_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // destination pointer: software load, hardware advance in mode 2
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_ptr <= '0;
        end else if (reg_we && (reg_sel == SEL_DST)) begin
            dst_ptr <= reg_wdata;
        end else if (done && (ctrl.mode == MODE_DST_RUN)) begin
            dst_ptr <= dst_ptr + step;
        end
    end

    // control word; underflow forces enable off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (underflow) ctrl.en <= 1'b0;
        end
    end

    // activation marker: first accepted request reloads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b0;
        end else if (wr_ctrl && reg_wdata[0] && !ctrl.en) begin
            fresh_q <= 1'b1;
        end else if (take) begin
            fresh_q <= 1'b0;
        end
    end

    // running pointer and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_ptr <= '0;
            count_q <= '0;
        end else if (take && fresh_q) begin
            run_ptr <= src_ptr;
            count_q <= reload_q;
        end else if (done) begin
            count_q <= count_q - 1'b1;
            if (ctrl.mode == MODE_SRC_RUN) run_ptr <= run_ptr + step;
        end
    end

    // interrupt flag: setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (underflow) begin
            irq <= 1'b1;
        end else if (irq_ack || (wr_irq && !reg_wdata[0])) begin
            irq <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        unique case (reg_sel)
            SEL_SRC:    reg_rdata = src_ptr;
            SEL_DST:    reg_rdata = dst_ptr;
            SEL_RELOAD: reg_rdata = ADDR_W'(reload_q);
            SEL_CTRL:   reg_rdata = ADDR_W'(ctrl);
            SEL_SWREQ:  reg_rdata = '0;
            SEL_IRQ:    reg_rdata = ADDR_W'(irq);
            SEL_RUNPTR: reg_rdata = run_ptr;
            SEL_COUNT:  reg_rdata = ADDR_W'(count_q);
            default:    reg_rdata = '0;
        endcase
    end

    // R4
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fresh_q) |=> (run_ptr == $past(src_ptr) && count_q == $past(reload_q)));

    // R7
    underflow_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (!ctrl.en && irq && count_q == '1));

    // R9
    set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && irq_ack) |=> irq);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !underflow) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/dma_oneshot_chan.sv
`timescale 1ns/1ps
module dma_oneshot_chan
    import dma_oneshot_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              ext_req,
    input  logic              irq_ack,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_wide,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    ctrl_t             ctrl;
    logic              sw_hit, pend, take, done, go;
    logic [ADDR_W-1:0] run_ptr, dst_ptr;

    always_comb begin
        go = pend && ctrl.en;
    end

    dma_regfile #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .take      (take),
        .done      (done),
        .irq_ack   (irq_ack),
        .ctrl      (ctrl),
        .sw_hit    (sw_hit),
        .run_ptr   (run_ptr),
        .dst_ptr   (dst_ptr),
        .irq       (irq)
    );

    dma_req_gate i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.en),
        .sw_sel  (ctrl.sw_sel),
        .sw_hit  (sw_hit),
        .ext_req (ext_req),
        .take    (take),
        .pend    (pend)
    );

    dma_bus_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .wide      (ctrl.wide),
        .rd_ptr    (run_ptr),
        .wr_ptr    (dst_ptr),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .take      (take),
        .done      (done),
        .bus_req   (bus_req),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wide  (bus_wide),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    // R3
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(ctrl.en));

endmodule

// File: tb/test_dma_oneshot_chan.sv
`timescale 1ns/1ps
module test_dma_oneshot_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_we = 1'b0;
    logic [19:0] reg_wdata = '0;
    logic [19:0] reg_rdata;
    logic        ext_req = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [19:0] bus_addr;
    logic        bus_rd, bus_wr, bus_wide;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk; // 50 MHz

    dma_oneshot_chan i_dma_oneshot_chan (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
        .irq_ack(irq_ack), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_of(input logic [19:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    task automatic wr_reg(input logic [2:0] s, input logic [19:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [19:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_req = 1'b1;
        @(negedge clk); ext_req = 1'b0;
    endtask

    task automatic quiet_bus(input string what);
        logic seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seen = seen | bus_req | bus_rd | bus_wr;
        end
        chk(what, seen, 1'b0);
    endtask

    task automatic run_xfer(input logic [19:0] rd_a, input logic [19:0] wr_a,
                            input logic wide, input logic ack_wr, input string tag);
        int n = 0;
        logic [15:0] exp_d;
        exp_d = wide ? mem_of(rd_a) : {8'h00, mem_of(rd_a)[7:0]};
        while (!bus_req && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R5 request raised"}, {bus_req, bus_rd, bus_wr}, 3'b100);
        @(negedge clk);
        chk({tag, " R5 wait for grant"}, {bus_req, bus_rd, bus_wr}, 3'b100);
        bus_gnt = 1'b1;
        @(negedge clk);
        chk({tag, " R5 leading dummy"}, {bus_req, bus_rd, bus_wr}, 3'b100);
        @(negedge clk);
        chk({tag, " R5 read strobe"}, {bus_req, bus_rd, bus_wr}, 3'b110);
        chk({tag, " R5 read addr"}, bus_addr, rd_a);
        chk({tag, " R10 unit size"}, bus_wide, wide);
        bus_rdata = mem_of(rd_a);
        @(negedge clk);
        chk({tag, " R5 write strobe"}, {bus_req, bus_rd, bus_wr}, 3'b101);
        chk({tag, " R5 write addr"}, bus_addr, wr_a);
        chk({tag, " R10 write data"}, bus_wdata, exp_d);
        irq_ack = ack_wr;
        @(negedge clk);
        irq_ack = 1'b0;
        chk({tag, " R5 trailing dummy"}, {bus_req, bus_rd, bus_wr}, 3'b000);
        bus_gnt = 1'b0;
        bus_rdata = '0;
    endtask

    task automatic t_reset();
        logic [19:0] v;
        rd_reg(3'd3, v); chk("R1 control", v, 0);
        rd_reg(3'd5, v); chk("R1 irq flag", v, 0);
        rd_reg(3'd7, v); chk("R1 counter", v, 0);
        rd_reg(3'd6, v); chk("R1 running pointer", v, 0);
        chk("R1 bus idle", {bus_req, bus_rd, bus_wr, irq}, 4'b0000);
    endtask

    task automatic t_disabled();
        wr_reg(3'd3, 20'h16);          // sw trigger, disabled
        wr_reg(3'd4, 20'h1);
        pulse_ext();
        quiet_bus("R3 request while disabled");
        wr_reg(3'd3, 20'h17);          // enable now
        quiet_bus("R3 nothing stored while disabled");
        wr_reg(3'd3, 20'h00);
    endtask

    task automatic t_sw_two();
        logic [19:0] v;
        wr_reg(3'd0, 20'h12340);
        wr_reg(3'd1, 20'h00800);
        wr_reg(3'd2, 20'h1);
        wr_reg(3'd3, 20'h17);          // sw, mode1, wide, en
        wr_reg(3'd4, 20'h1);
        run_xfer(20'h12340, 20'h00800, 1'b1, 1'b0, "R2 sw first");
        rd_reg(3'd7, v); chk("R4 R6 counter after first", v, 20'h00);
        rd_reg(3'd6, v); chk("R11 R10 run ptr step 2", v, 20'h12342);
        rd_reg(3'd1, v); chk("R11 dst fixed", v, 20'h00800);
        wr_reg(3'd4, 20'h1);
        run_xfer(20'h12342, 20'h00800, 1'b1, 1'b0, "R6 sw second");
        rd_reg(3'd7, v); chk("R6 counter underflow", v, 20'hFF);
        rd_reg(3'd3, v); chk("R7 enable cleared", v, 20'h16);
        chk("R7 irq set", irq, 1'b1);
        wr_reg(3'd4, 20'h1);
        quiet_bus("R3 request after stop");
        wr_reg(3'd5, 20'h0);
        rd_reg(3'd5, v); chk("R8 sw clear", v, 20'h0);
    endtask

    task automatic t_ext_byte();
        logic [19:0] v;
        wr_reg(3'd0, 20'h00010);
        wr_reg(3'd1, 20'hFFFFF);
        wr_reg(3'd2, 20'h0);
        wr_reg(3'd3, 20'h09);          // ext, mode2, byte, en
        wr_reg(3'd4, 20'h1);
        quiet_bus("R2 sw ignored on pin trigger");
        pulse_ext();
        run_xfer(20'h00010, 20'hFFFFF, 1'b0, 1'b0, "R2 ext");
        rd_reg(3'd1, v); chk("R12 dst wrap", v, 20'h00000);
        rd_reg(3'd6, v); chk("R11 run ptr fixed", v, 20'h00010);
        chk("R7 irq after single", irq, 1'b1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk("R8 ack clear", irq, 1'b0);
    endtask

    task automatic t_src_wrap();
        logic [19:0] v;
        wr_reg(3'd0, 20'hFFFFE);
        wr_reg(3'd1, 20'h00400);
        wr_reg(3'd3, 20'h17);
        pulse_ext();
        quiet_bus("R2 pin ignored on sw trigger");
        wr_reg(3'd4, 20'h1);
        run_xfer(20'hFFFFE, 20'h00400, 1'b1, 1'b0, "R12 src");
        rd_reg(3'd6, v); chk("R12 run ptr wrap", v, 20'h00000);
        wr_reg(3'd5, 20'h0);
    endtask

    task automatic t_fixed_ack();
        logic [19:0] v;
        wr_reg(3'd0, 20'h20000);
        wr_reg(3'd1, 20'h30000);
        wr_reg(3'd2, 20'h1);
        wr_reg(3'd3, 20'h13);          // sw, mode0, wide, en
        wr_reg(3'd4, 20'h1);
        run_xfer(20'h20000, 20'h30000, 1'b1, 1'b0, "R11 fixed 1");
        wr_reg(3'd4, 20'h1);
        run_xfer(20'h20000, 20'h30000, 1'b1, 1'b1, "R9 fixed 2");
        chk("R9 underflow beats ack", irq, 1'b1);
        rd_reg(3'd3, v); chk("R9 enable cleared", v, 20'h12);
        rd_reg(3'd6, v); chk("R11 src unchanged", v, 20'h20000);
        rd_reg(3'd1, v); chk("R11 dst unchanged", v, 20'h30000);
        wr_reg(3'd5, 20'h0);
    endtask

    task automatic t_held();
        logic [19:0] v;
        wr_reg(3'd0, 20'h40000);
        wr_reg(3'd1, 20'h50000);
        wr_reg(3'd2, 20'h2);
        wr_reg(3'd3, 20'h15);          // sw, mode1, byte, en
        wr_reg(3'd4, 20'h1);
        wr_reg(3'd4, 20'h1);           // arrives while waiting for grant
        run_xfer(20'h40000, 20'h50000, 1'b0, 1'b0, "R13 first");
        run_xfer(20'h40001, 20'h50000, 1'b0, 1'b0, "R13 held");
        rd_reg(3'd7, v); chk("R13 R6 counter", v, 20'h00);
        rd_reg(3'd3, v); chk("R13 still enabled", v, 20'h15);
        quiet_bus("R13 only one held");
        wr_reg(3'd4, 20'h1);
        run_xfer(20'h40002, 20'h50000, 1'b0, 1'b0, "R6 third");
        rd_reg(3'd7, v); chk("R6 wrap to all ones", v, 20'hFF);
        chk("R7 irq", irq, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_sw_two();
        t_ext_byte();
        t_src_wrap();
        t_fixed_ack();
        t_held();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule